// File: doc/BRIEF.md
# Programmable Reload Countdown Timer

This block is an interval timer placed on a byte-wide register port. Software writes a 16-bit reload value, one byte per register, and then writes a start strobe. The strobe copies the reload value into an internal down-counter in the same clock edge. Each cycle in which the tick-enable input is high, the counter steps down by one. When it would reach zero, the counter loads the reload value again and raises a sticky interrupt request. Software clears the request by writing an acknowledge register.

The live count is never visible on the read port. Software first writes a snapshot command, which copies the count into a latch register. It then reads the latch through the same byte offsets that take the reload value on writes. A read and a write at one of these offsets therefore reach different registers.

Control is a two-state machine. `TMR_IDLE` is the state after reset: the counter is frozen and no interrupt can occur. The transition `start` (a write to the GO offset) moves it to `TMR_RUN`. In `TMR_RUN` the transition `start` reloads the counter and keeps the state, and so does the transition `wrap`, which is the zero event. Only reset leaves `TMR_RUN`.

Top module: `reload_timer`

## Requirements
- R1: After reset, `irq` is 0 and reads at offsets 0x00 and 0x04 return 0.
- R2: A write to 0x00 sets bits 7:0 of the reload value and a write to 0x04 sets bits 15:8. These registers are write-only: reads at those offsets return the latch, never the reload value.
- R3: A write of any data to offset 0x08 (start) loads the counter with the reload value at that clock edge and puts the block in `TMR_RUN`.
- R4: A write to 0x0C with data bit 0 = 1 copies the current count into the latch. A write to 0x0C with bit 0 = 0 leaves the latch unchanged.
- R5: In `TMR_RUN`, each cycle with `tick` high lowers the count by one. A reload value R gives a zero event every R ticks, and the counter then holds R again. A reload of 20,000 with a 2 MHz tick therefore gives 100 events per second.
- R6: `irq` is set in the cycle after a zero event and stays set until a write to offset 0x10. If a zero event and that write occur in the same cycle, `irq` ends up set.
- R7: Before the first start, ticks do not change the count (0) and never raise `irq`.
- R8: A reload value of 0 gives a period of 65,536 ticks.
- R9: When a start write and a tick occur in the same cycle, the counter takes the reload value, with no decrement and no zero event.
- R10: Reads at any offset other than 0x00 and 0x04 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench goes after the cycles where two actions collide.
- A start in the same cycle as a tick must give exactly the reload value. A design where the tick wins would read one less, or would fire a spurious interrupt when the count was 1.
- An acknowledge in the same cycle as a zero event must leave `irq` set. A design where the clear wins loses that interrupt.
- The reload-of-zero period and the 20,000-tick period are each checked one tick before the event and at the event. An off-by-one wrap shows up as an early or late `irq`.
- Reads at the reload offsets are checked after writing a reload value different from the latch. A design that decodes the read side wrong would return the reload value.
- Random reload values and tick counts are compared against a period function computed in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_q,
    output logic             zero_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start (IDLE->RUN, RUN->RUN), wrap (RUN->RUN)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: if (go) state_d = TMR_RUN;
            TMR_RUN:  state_d = TMR_RUN;
        endcase
    end

    // outputs: zero event when a tick would take the count to zero
    always_comb begin
        zero_evt = (state_q == TMR_RUN) && tick && !go && (count_q == ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             count_q <= '0;
        else if (go)                            count_q <= reload;
        else if (state_q == TMR_RUN && tick) begin
            if (count_q == ONE)                 count_q <= reload;
            else                                count_q <= count_q - ONE;
        end
    end

    assert_go_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (count_q == $past(reload)));
    assert_tick_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && tick && !go && count_q != ONE) |=> (count_q == $past(count_q) - ONE));
    assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && tick && !go && count_q == ONE) |=> (count_q == $past(reload)));
    assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_IDLE && !go) |=> $stable(count_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count_q,
    input  logic              zero_evt,
    output logic [CNT_W-1:0]  reload_q,
    output logic              go,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int BYTES = CNT_W / DATA_W;
    localparam logic [ADDR_W-1:0] GO_OFS    = ADDR_W'(4 * BYTES);
    localparam logic [ADDR_W-1:0] LATCH_OFS = ADDR_W'(4 * BYTES + 4);
    localparam logic [ADDR_W-1:0] ACK_OFS   = ADDR_W'(4 * BYTES + 8);

    logic [CNT_W-1:0] latch_q;
    logic             latch_wr, ack_wr;

    assign go       = bus_wr && (bus_addr == GO_OFS);
    assign latch_wr = bus_wr && (bus_addr == LATCH_OFS) && bus_wdata[0];
    assign ack_wr   = bus_wr && (bus_addr == ACK_OFS);

    for (genvar i = 0; i < BYTES; i++) begin : g_reload
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                reload_q[i*DATA_W +: DATA_W] <= '0;
            else if (bus_wr && bus_addr == ADDR_W'(4 * i))
                reload_q[i*DATA_W +: DATA_W] <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        latch_q <= '0;
        else if (latch_wr) latch_q <= count_q;
    end

    // set beats clear so no zero event is lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq <= 1'b0;
        else if (zero_evt) irq <= 1'b1;
        else if (ack_wr)   irq <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < BYTES; i++)
            if (bus_addr == ADDR_W'(4 * i)) bus_rdata = latch_q[i*DATA_W +: DATA_W];
    end

    assert_latch_snap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_wr |=> (latch_q == $past(count_q)));
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_wr |=> $stable(latch_q));
    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq);
    assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> irq);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] reload_q, count_q;
    logic             go, zero_evt;

    tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count_q(count_q), .zero_evt(zero_evt),
        .reload_q(reload_q), .go(go), .bus_rdata(bus_rdata), .irq(irq)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .reload(reload_q),
        .count_q(count_q), .zero_evt(zero_evt)
    );
endmodule

// File: tb/sim_reload_timer.sv
`timescale 1ns/1ps
module sim_reload_timer;
    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    reload_timer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always #2 clk = ~clk;

    function automatic logic [15:0] exp_count(input logic [15:0] r, input int k);
        int p = (r == 16'd0) ? 65536 : int'(r);
        int m = k % p;
        return (m == 0) ? r : 16'(p - m);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
    endtask

    task automatic read16(output logic [15:0] v);
        bus_addr = 5'h00; #0.2 v[7:0] = bus_rdata;
        bus_addr = 5'h04; #0.2 v[15:8] = bus_rdata;
        bus_addr = 5'h00;
        @(negedge clk);
    endtask

    task automatic snap(output logic [15:0] v);
        wr(5'h0C, 8'h01);
        read16(v);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic set_reload(input logic [15:0] r);
        wr(5'h00, r[7:0]);
        wr(5'h04, r[15:8]);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", irq, 0);
        read16(v); check("R1 latch", v, 0);
        // R10 other offsets
        bus_addr = 5'h08; #0.2 check("R10 rd 0x08", bus_rdata, 0);
        bus_addr = 5'h10; #0.2 check("R10 rd 0x10", bus_rdata, 0);
        bus_addr = 5'h00; @(negedge clk);
        // R7 idle before start
        set_reload(16'd5);
        ticks(12);
        check("R7 irq", irq, 0);
        snap(v); check("R7 count", v, 0);
        // R2 write-only: reads return latch not reload
        set_reload(16'hA5C3);
        read16(v); check("R2 readback is latch", v, 0);
        // R3 start loads reload
        wr(5'h08, 8'h00);
        snap(v); check("R3 load", v, 16'hA5C3);
        // R5 decrement
        ticks(7);
        snap(v); check("R5 dec", v, 16'hA5C3 - 7);
        // R4 latch with bit0 clear is ignored
        ticks(3);
        wr(5'h0C, 8'hFE);
        read16(v); check("R4 no snap", v, 16'hA5C3 - 7);
        snap(v); check("R4 snap", v, 16'hA5C3 - 10);
        // R9 start with tick, mid count
        set_reload(16'd10);
        wr(5'h08, 8'h00); ticks(3);
        tick = 1'b1; wr(5'h08, 8'h00); tick = 1'b0;
        snap(v); check("R9 start beats tick", v, 10);
        // R9 start with tick at count 1: no event
        set_reload(16'd5);
        wr(5'h08, 8'h00); wr(5'h10, 8'h00); ticks(4);
        tick = 1'b1; wr(5'h08, 8'h00); tick = 1'b0;
        check("R9 no irq", irq, 0);
        snap(v); check("R9 count", v, 5);
        // R6 sticky, set beats ack
        ticks(4);
        tick = 1'b1; wr(5'h10, 8'h00); tick = 1'b0;
        check("R6 set beats ack", irq, 1);
        ticks(2);
        check("R6 sticky", irq, 1);
        wr(5'h10, 8'h00);
        check("R6 ack clears", irq, 0);
        // R5 period of 20000
        set_reload(16'd20000);
        wr(5'h08, 8'h00); wr(5'h10, 8'h00);
        ticks(19999);
        check("R5 20000 early", irq, 0);
        ticks(1);
        check("R5 20000 event", irq, 1);
        snap(v); check("R5 20000 reload", v, 20000);
        // R8 reload of zero
        set_reload(16'd0);
        wr(5'h08, 8'h00); wr(5'h10, 8'h00);
        ticks(65535);
        check("R8 early", irq, 0);
        snap(v); check("R8 count", v, 1);
        ticks(1);
        check("R8 event", irq, 1);
        snap(v); check("R8 reload", v, 0);
        // random reload / tick counts
        for (int it = 0; it < 25; it++) begin
            logic [15:0] r = 16'(1 + $urandom % 60);
            int k = $urandom % 150;
            set_reload(r);
            wr(5'h08, 8'h00); wr(5'h10, 8'h00);
            ticks(k);
            check("R5 rand irq", irq, (k >= int'(r)) ? 1 : 0);
            snap(v); check("R5 rand count", v, exp_count(r, k));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule